// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a direct-mapped data cache placed between a processor's load/store port and a slower word-wide main memory. Each line holds a block of four 32-bit words. A CPU byte address is cut into a byte offset, a word select, a line index and a tag. A read that finds a valid line with a matching tag is answered combinationally in the same cycle, with no stall.

A read or write that misses stalls the processor. The controller then fetches the whole block from memory as four word reads, each closed by a ready handshake, and commits the block to the line. After that the access is re-evaluated and hits. Every write that hits updates the cached word and is also sent through to memory. The stall is held until memory acknowledges that write.

The processor holds its request and its inputs steady while the stall is high. An access completes on the first rising edge at which the stall is low.

Top module: `dm_wt_cache`

## Requirements
- R1: After reset no line is valid, so the first access to any line stalls. With no request, the stall output and the memory request are both low.
- R2: Address bits [1:0] are ignored. Bits [3:2] select the word within the block (0 is the lowest address). Bits [4+INDEX_W-1:4] pick the line, and the remaining upper bits form the tag.
- R3: A hit requires both the line's valid bit and a tag match. An access to the same line with a different tag misses and replaces the line, so the earlier block then misses again.
- R4: A read hit returns the selected word in the same cycle, with the stall low and no memory request.
- R5: A miss performs exactly four memory reads at the block-aligned addresses, in ascending word order. Each word is taken in a cycle where the memory ready input is high.
- R6: After the fill, the line is committed in one extra stalled cycle. The held access then hits without any further memory traffic.
- R7: A write hit updates the cached word and drives one memory write carrying the CPU address and data. The stall stays high until the cycle in which memory signals ready.
- R8: A write miss first fetches the whole block, then writes the word into it. The other three words keep their memory values.
- R9: Only one memory operation is in flight at a time. The memory address is held steady while a fill word is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | CPU byte address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | Read data, valid when the stall is low |
| cpu_stall | output | 1 | Hold the access |
| mem_req | output | 1 | Memory operation request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| mem_ready | input | 1 | Memory has completed the operation |

## Verification
A wrong valid bit or tag shows up at once at the ports. Either a stall appears on an access that should hit, or data comes back with no fill on an access that should miss. Both are visible in the first cycle of the access. A miscounted fill shows up as a wrong number of memory reads, or as a word landing in the wrong slot. Either becomes visible on the very next read hit to that block. A lost write-through shows up as memory contents that differ from the cache, which a read of the same address after a conflicting refill exposes.

// File: rtl/dm_wt_cache.sv
module dm_wt_cache #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 8,
  parameter int WORDS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready
);
  localparam int OFF_W  = $clog2(DATA_W / 8);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int TAG_W  = ADDR_W - INDEX_W - WSEL_W - OFF_W;
  localparam int LINES  = 1 << INDEX_W;
  localparam int LINE_W = DATA_W * WORDS;

  typedef enum logic [1:0] {IDLE, FILL, WRITE_THRU, RESPOND} st_t;

  st_t                 state_q;
  logic [LINES-1:0]    valid_q;
  logic [TAG_W-1:0]    tag_q  [LINES];
  logic [LINE_W-1:0]   data_q [LINES];
  logic [LINE_W-1:0]   fill_buf;
  logic [WSEL_W-1:0]   cnt_q;
  logic [TAG_W-1:0]    a_tag;
  logic [INDEX_W-1:0]  a_idx;
  logic [ADDR_W-1:0]   wt_addr;
  logic [DATA_W-1:0]   wt_data;

  logic [TAG_W-1:0]    c_tag;
  logic [INDEX_W-1:0]  c_idx;
  logic [WSEL_W-1:0]   c_wsel;
  logic                hit;
  logic [LINE_W-1:0]   c_line;
  logic                last_word;

  assign c_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
  assign c_idx  = cpu_addr[OFF_W+WSEL_W +: INDEX_W];
  assign c_wsel = cpu_addr[OFF_W +: WSEL_W];
  assign hit    = valid_q[c_idx] && (tag_q[c_idx] == c_tag);
  assign c_line = data_q[c_idx];
  assign cpu_rdata = c_line[c_wsel*DATA_W +: DATA_W];
  assign last_word = (cnt_q == WSEL_W'(WORDS - 1));

  assign mem_req   = (state_q == FILL) || (state_q == WRITE_THRU);
  assign mem_we    = (state_q == WRITE_THRU);
  assign mem_wdata = wt_data;
  assign mem_addr  = (state_q == WRITE_THRU) ? wt_addr :
                     (state_q == FILL) ? {a_tag, a_idx, cnt_q, {OFF_W{1'b0}}} : '0;

  always_comb begin
    case (state_q)
      IDLE:       cpu_stall = cpu_req && !(hit && !cpu_we);
      WRITE_THRU: cpu_stall = !mem_ready;
      default:    cpu_stall = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= IDLE;
      valid_q  <= '0;
      cnt_q    <= '0;
      a_tag    <= '0;
      a_idx    <= '0;
      wt_addr  <= '0;
      wt_data  <= '0;
      fill_buf <= '0;
    end else begin
      case (state_q)
        IDLE: if (cpu_req) begin
          if (!hit) begin
            state_q <= FILL;
            a_tag   <= c_tag;
            a_idx   <= c_idx;
            cnt_q   <= '0;
          end else if (cpu_we) begin
            state_q <= WRITE_THRU;
            wt_addr <= cpu_addr;
            wt_data <= cpu_wdata;
          end
        end
        FILL: if (mem_ready) begin
          fill_buf[cnt_q*DATA_W +: DATA_W] <= mem_rdata;
          cnt_q <= cnt_q + 1'b1;
          if (last_word) state_q <= RESPOND;
        end
        RESPOND: begin
          valid_q[a_idx] <= 1'b1;
          state_q        <= IDLE;
        end
        WRITE_THRU: if (mem_ready) state_q <= IDLE;
        default: state_q <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state_q == IDLE && cpu_req && cpu_we && hit)
      data_q[c_idx][c_wsel*DATA_W +: DATA_W] <= cpu_wdata;
    if (state_q == RESPOND) begin
      data_q[a_idx] <= fill_buf;
      tag_q[a_idx]  <= a_tag;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == IDLE && !cpu_req) |-> (!cpu_stall && !mem_req));

  a_r3_miss_starts_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == IDLE && cpu_req && !hit) |=> (state_q == FILL));

  a_r4_read_hit_no_traffic: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == IDLE && cpu_req && !cpu_we && hit) |-> (!cpu_stall && !mem_req));

  a_r6_commit_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RESPOND) |=> valid_q[a_idx]);

  a_r7_stall_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WRITE_THRU && !mem_ready) |-> (cpu_stall && mem_we));

  a_r8_fill_reads_only: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FILL) |-> (mem_req && !mem_we));

  a_r9_fill_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FILL && !mem_ready) |=> (mem_addr == $past(mem_addr)));
endmodule

// File: tb/dm_wt_cache_test.sv
module dm_wt_cache_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic        cpu_stall;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ready;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  dm_wt_cache uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  logic [31:0] wmem [int unsigned];
  logic [31:0] rd_log [4];
  int rd_cnt = 0, wr_cnt = 0, seq = 0, last_rd_seq = 0, last_wr_seq = 0;
  logic [31:0] last_wa, last_wd, rdata_q;
  logic ready_q;

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    if (wmem.exists(a)) return wmem[a];
    return a ^ 32'hA5A5_0000;
  endfunction

  assign mem_ready = ready_q;
  assign mem_rdata = rdata_q;

  always @(posedge clk) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      rdata_q <= '0;
    end else if (ready_q) begin
      ready_q <= 1'b0;
      seq = seq + 1;
      if (mem_we) begin
        wmem[mem_addr] = mem_wdata;
        last_wa = mem_addr;
        last_wd = mem_wdata;
        wr_cnt = wr_cnt + 1;
        last_wr_seq = seq;
      end else begin
        rd_log[rd_cnt % 4] = mem_addr;
        rd_cnt = rd_cnt + 1;
        last_rd_seq = seq;
      end
    end else if (mem_req) begin
      ready_q <= 1'b1;
      rdata_q <= mem_val(mem_addr);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] q, output int stalls);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    stalls = 0;
    #1;
    while (cpu_stall && stalls < 500) begin
      stalls++;
      @(negedge clk); #1;
    end
    q = cpu_rdata;
    @(posedge clk); #1;
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 idle stall", {31'd0, cpu_stall}, 32'd0);
    chk("R1 idle mem_req", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic t_read_miss();
    logic [31:0] q; int s; int r0;
    r0 = rd_cnt;
    access(1'b0, 32'h0000_0124, '0, q, s);
    chk("R1 first access stalls", {31'd0, s > 0}, 32'd1);
    chk("R5 miss data", q, mem_val(32'h0000_0124));
    chk("R6 exactly four reads", rd_cnt - r0, 4);
    for (int i = 0; i < 4; i++)
      chk("R5 fill order", rd_log[(r0 + i) % 4], 32'h0000_0120 + 32'(4 * i));
  endtask

  task automatic t_read_hit();
    logic [31:0] q; int s; int r0;
    r0 = rd_cnt;
    access(1'b0, 32'h0000_012C, '0, q, s);
    chk("R4 hit no stall", s, 0);
    chk("R4 hit data", q, mem_val(32'h0000_012C));
    access(1'b0, 32'h0000_012B, '0, q, s);
    chk("R2 byte offset ignored", q, mem_val(32'h0000_0128));
    chk("R2 hit no stall", s, 0);
    chk("R4 no memory reads", rd_cnt - r0, 0);
  endtask

  task automatic t_conflict();
    logic [31:0] q; int s; int r0;
    r0 = rd_cnt;
    access(1'b0, 32'h0000_1124, '0, q, s);
    chk("R3 other tag misses", {31'd0, s > 0}, 32'd1);
    chk("R3 refill data", q, mem_val(32'h0000_1124));
    chk("R3 refill reads", rd_cnt - r0, 4);
    access(1'b0, 32'h0000_0120, '0, q, s);
    chk("R3 evicted block misses", {31'd0, s > 0}, 32'd1);
    chk("R3 evicted block data", q, mem_val(32'h0000_0120));
  endtask

  task automatic t_write_hit();
    logic [31:0] q; int s; int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    access(1'b1, 32'h0000_0120, 32'hDEAD_BEEF, q, s);
    chk("R7 write stalls", {31'd0, s > 0}, 32'd1);
    chk("R7 one mem write", wr_cnt - w0, 1);
    chk("R7 write addr", last_wa, 32'h0000_0120);
    chk("R7 write data", last_wd, 32'hDEAD_BEEF);
    chk("R7 no reads on hit", rd_cnt - r0, 0);
    access(1'b0, 32'h0000_0120, '0, q, s);
    chk("R7 cached word updated", q, 32'hDEAD_BEEF);
    chk("R7 readback no stall", s, 0);
  endtask

  task automatic t_write_miss();
    logic [31:0] q; int s; int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    access(1'b1, 32'h0000_2348, 32'h1234_5678, q, s);
    chk("R8 block fetched", rd_cnt - r0, 4);
    chk("R8 one write", wr_cnt - w0, 1);
    chk("R9 write after fill", {31'd0, last_wr_seq > last_rd_seq}, 32'd1);
    access(1'b0, 32'h0000_2340, '0, q, s);
    chk("R8 neighbour word", q, mem_val(32'h0000_2340));
    chk("R8 neighbour hit", s, 0);
    access(1'b0, 32'h0000_2348, '0, q, s);
    chk("R8 merged word", q, 32'h1234_5678);
  endtask

  task automatic t_reset_clears();
    logic [31:0] q; int s;
    do_reset();
    access(1'b0, 32'h0000_0120, '0, q, s);
    chk("R1 reset invalidates", {31'd0, s > 0}, 32'd1);
    chk("R1 data after reset", q, 32'hDEAD_BEEF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_read_miss();
    t_read_hit();
    t_conflict();
    t_write_hit();
    t_write_miss();
    t_reset_clears();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule